// File: doc/BRIEF.md
# USB Input Source Type Classifier

This block works out what kind of USB power source has been attached to a charger input. From the result it reports an input current limit and a 3-bit source code. It steps through a fixed sequence. First comes data-contact detection, then primary and secondary port detection. If contact never appears, a fallback decode reads the D+ and D- voltage windows that a resistor-divider adapter sets up. When a dedicated charging port is found, an optional high-voltage request handshake follows. The analog front end is outside the block. It supplies comparator flags and takes digital enable lines for its D+/D- sources and sinks.

All delays are counted in ticks of a parameterised clock-enable divider, so a bench can shorten them. Every comparator flag passes through a two-flop synchroniser and a stability filter before the sequencer uses it. The `vbus_present` input is taken to be synchronous to `clk` already. When the sequence finishes, the block latches the limit and code, raises a done flag and sends one interrupt pulse. Dropping `vbus_present` resets everything at once.

Top module: `usb_src_classifier`

## Requirements
- R1: While reset is held, and right after it, every output is 0: done flag, interrupt, current-limit code, source code and all seven drive enables.
- R2: After the source is plugged in, the contact stage drives only `dp_idp_src_en`. A filtered contact flag moves the block on to primary detection without waiting for the contact timeout, so a standard port is reported in fewer than `DCD_TICKS` ticks.
- R3: If the primary flag is low when the primary settle time ends (`dp_vsrc_en` and `dm_isink_en` driven), the result is a standard port: `ilim_code`=10, `src_stat`=3'b001.
- R4: If the primary flag is high and the secondary flag is low after the secondary settle time (`dm_vsrc_en` and `dp_isink_en` driven), the result is a charging downstream port: `ilim_code`=30, `src_stat`=3'b010.
- R5: If both flags are high and both high-voltage enables are clear, the result is a dedicated port: `ilim_code`=65, `src_stat`=3'b011.
- R6: For a dedicated port with `hv12_en`=1, the 12 V request is tried first, with `dp_isink_en` and `dm_hv_src_en` driven. If `hv_up` is high when the request time ends, the result is a high-voltage adapter (`ilim_code`=30, `src_stat`=3'b100), and that drive pair is held for as long as the source stays attached.
- R7: The 9 V request (`dp_hv_src_en` and `dm_isink_en`) is made when `hv9_en`=1 and either `hv12_en`=0 or the 12 V request failed. On success it gives the R6 result and holds the 9 V pair. If no request succeeds, the result is a dedicated port and every drive enable is released.
- R8: If no contact is seen within `DCD_TICKS` ticks, the divider decode runs after a settle time. Its result never appears before `DCD_TICKS` ticks have passed.
- R9: The window flags are one-hot: bit 0 is 1.2 V, bit 1 is 2.0 V, bit 2 is 2.7 V. The divider decode matches exactly and reports `src_stat`=3'b110 with these limits: D+ 2.7/D- 2.0 gives 42; both 1.2 gives 40; D+ 2.0/D- 2.7 gives 20; both 2.7 gives 48. `ilim_code` counts in 50 mA steps.
- R10: Any window pattern that matches no divider row gives an unknown adapter: `ilim_code`=10, `src_stat`=3'b101.
- R11: On completion, `det_done`, `ilim_code` and `src_stat` all change in the same cycle as a one-cycle `det_irq` pulse. There is exactly one pulse per attach, and the results hold until removal.
- R12: One clock after `vbus_present` goes low, `det_done`, `det_irq`, both result codes and every drive enable are 0. This holds even when removal falls in the same cycle as completion.
- R13: A comparator flag change that lasts less than `FILT_TICKS` ticks has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vbus_present | input | 1 | Source attached (synchronous) |
| hv12_en | input | 1 | Allow the 12 V request |
| hv9_en | input | 1 | Allow the 9 V request |
| dcd_ok | input | 1 | Data contact comparator flag |
| pri_hi | input | 1 | Primary detection comparator flag |
| sec_hi | input | 1 | Secondary detection comparator flag |
| dp_win | input | 3 | D+ window flags, one-hot (1.2/2.0/2.7 V) |
| dm_win | input | 3 | D- window flags, one-hot (1.2/2.0/2.7 V) |
| hv_up | input | 1 | Bus voltage raised by adapter |
| dp_idp_src_en | output | 1 | D+ contact-test current source |
| dp_vsrc_en | output | 1 | D+ low-level voltage source |
| dm_vsrc_en | output | 1 | D- low-level voltage source |
| dp_isink_en | output | 1 | D+ current sink |
| dm_isink_en | output | 1 | D- current sink |
| dp_hv_src_en | output | 1 | D+ 3.45 V request source |
| dm_hv_src_en | output | 1 | D- 3.45 V request source |
| det_done | output | 1 | Detection complete |
| det_irq | output | 1 | One-cycle completion interrupt |
| ilim_code | output | 7 | Input current limit, 50 mA steps |
| src_stat | output | 3 | Source type code |

## Verification
Completion of a detection and removal of the source can land in the same clock cycle. In that case removal has to win: no interrupt appears, and no result stays latched. To provoke this, the bench repeatedly attaches a charging-port source and drops `vbus_present` after a delay that grows one cycle per pass, so one of the passes lines up with the completion cycle. In every pass it checks that the cycle after removal shows all outputs at zero and that at most one interrupt came in that attach.

// File: rtl/usbsc_pkg.sv
// Shared constants, types and the divider decode used by the classifier.
// Assumes window flags are one-hot: bit0 = 1.2 V, bit1 = 2.0 V, bit2 = 2.7 V.
package usbsc_pkg;

    // Comparator flag vector layout
    localparam int NFLAG = 10;
    localparam int F_DCD = 0;
    localparam int F_PRI = 1;
    localparam int F_SEC = 2;
    localparam int F_HV  = 3;
    localparam int F_DPW = 4;
    localparam int F_DMW = 7;

    // Drive enable vector layout
    localparam int ND    = 7;
    localparam int D_IDP = 0;
    localparam int D_DPV = 1;
    localparam int D_DMV = 2;
    localparam int D_DPK = 3;
    localparam int D_DMK = 4;
    localparam int D_DPH = 5;
    localparam int D_DMH = 6;

    typedef enum logic [2:0] {
        S_IDLE, S_DCD, S_PRI, S_SEC, S_HV12, S_HV9, S_NSTD, S_DONE
    } st_t;

    typedef enum logic [1:0] {K_NONE, K_12, K_9} hold_t;

    typedef struct packed {
        logic [6:0] ilim;
        logic [2:0] stat;
    } res_t;

    localparam res_t R_SDP = res_t'({7'd10, 3'b001});
    localparam res_t R_CDP = res_t'({7'd30, 3'b010});
    localparam res_t R_DCP = res_t'({7'd65, 3'b011});
    localparam res_t R_HVA = res_t'({7'd30, 3'b100});
    localparam res_t R_UNK = res_t'({7'd10, 3'b101});

    // Exact-match decode of a divider-biased adapter; no match -> unknown
    function automatic res_t div_decode(input logic [2:0] dp, input logic [2:0] dm);
        res_t r;
        if (dp == 3'b100 && dm == 3'b010)      r = res_t'({7'd42, 3'b110});
        else if (dp == 3'b001 && dm == 3'b001) r = res_t'({7'd40, 3'b110});
        else if (dp == 3'b010 && dm == 3'b100) r = res_t'({7'd20, 3'b110});
        else if (dp == 3'b100 && dm == 3'b100) r = res_t'({7'd48, 3'b110});
        else                                   r = R_UNK;
        return r;
    endfunction

endpackage

// File: rtl/usbsc_tick.sv
// Clock-enable generator: one-cycle pulse every DIV clocks.
// Assumes DIV >= 1; DIV == 1 gives a permanent enable.
module usbsc_tick #(
    parameter int DIV = 125000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_always
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt;
            // Count clocks and wrap at DIV-1
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (cnt == CW'(DIV - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            assign tick = (cnt == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/usbsc_flag_filter.sv
// Two-flop synchroniser plus per-bit stability filter. A filtered bit
// takes a new value only after the synchronised input has differed from
// it for FILT ticks in a row. Assumes FILT >= 1.
module usbsc_flag_filter #(
    parameter int W    = 10,
    parameter int FILT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] raw,
    output logic [W-1:0] clean
);
    localparam int CW = $clog2(FILT + 1);

    logic [W-1:0] s1, s2;

    // Bring asynchronous comparator flags into the clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
        end
    end

    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            logic [CW-1:0] cnt;
            logic          q;
            // Accept a new level once it has persisted for FILT ticks
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                    q   <= 1'b0;
                end else if (s2[g] == q) begin
                    cnt <= '0;
                end else if (tick) begin
                    if (cnt == CW'(FILT - 1)) begin
                        q   <= s2[g];
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
            assign clean[g] = q;
        end
    endgenerate
endmodule

// File: rtl/usbsc_seq.sv
// Detection sequencer: contact stage, primary/secondary stages, divider
// fallback and high-voltage request, then latches the result with a
// single interrupt. Source removal overrides everything in the same cycle.
// Assumes vbus is synchronous and flags are already filtered.
module usbsc_seq
    import usbsc_pkg::*;
#(
    parameter int DCD_TICKS    = 500,
    parameter int SETTLE_TICKS = 40,
    parameter int HV_TICKS     = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             vbus,
    input  logic             hv12_en,
    input  logic             hv9_en,
    input  logic [NFLAG-1:0] flags,
    output st_t              st,
    output hold_t            hold,
    output logic             done,
    output logic             irq,
    output res_t             res
);
    localparam int MAXA = (DCD_TICKS > SETTLE_TICKS) ? DCD_TICKS : SETTLE_TICKS;
    localparam int MAXT = (MAXA > HV_TICKS) ? MAXA : HV_TICKS;
    localparam int TW   = $clog2(MAXT + 1);

    logic [TW-1:0] tmr;
    logic [TW-1:0] lim_m1;
    logic          expired;
    st_t           nxt;
    logic          fin;
    res_t          fin_res;
    hold_t         fin_hold;

    // Select the wait length of the current stage
    always_comb begin
        case (st)
            S_DCD:         lim_m1 = TW'(DCD_TICKS - 1);
            S_HV12, S_HV9: lim_m1 = TW'(HV_TICKS - 1);
            default:       lim_m1 = TW'(SETTLE_TICKS - 1);
        endcase
    end

    assign expired = tick && (tmr == lim_m1);

    // Next-stage and completion decision
    always_comb begin
        nxt      = st;
        fin      = 1'b0;
        fin_res  = R_UNK;
        fin_hold = K_NONE;
        case (st)
            S_IDLE: if (vbus) nxt = S_DCD;
            S_DCD: begin
                if (flags[F_DCD])  nxt = S_PRI;
                else if (expired)  nxt = S_NSTD;
            end
            S_PRI: if (expired) begin
                if (flags[F_PRI]) nxt = S_SEC;
                else begin
                    fin = 1'b1; fin_res = R_SDP;
                end
            end
            S_SEC: if (expired) begin
                if (!flags[F_SEC]) begin
                    fin = 1'b1; fin_res = R_CDP;
                end else if (hv12_en) nxt = S_HV12;
                else if (hv9_en)      nxt = S_HV9;
                else begin
                    fin = 1'b1; fin_res = R_DCP;
                end
            end
            S_HV12: if (expired) begin
                if (flags[F_HV]) begin
                    fin = 1'b1; fin_res = R_HVA; fin_hold = K_12;
                end else if (hv9_en) nxt = S_HV9;
                else begin
                    fin = 1'b1; fin_res = R_DCP;
                end
            end
            S_HV9: if (expired) begin
                fin = 1'b1;
                if (flags[F_HV]) begin
                    fin_res = R_HVA; fin_hold = K_9;
                end else begin
                    fin_res = R_DCP;
                end
            end
            S_NSTD: if (expired) begin
                fin     = 1'b1;
                fin_res = div_decode(flags[F_DPW +: 3], flags[F_DMW +: 3]);
            end
            default: nxt = st;
        endcase
        if (fin) nxt = S_DONE;
    end

    // State, stage timer and latched result; removal clears all of it
    always_ff @(posedge clk) begin
        if (!rst_n || !vbus) begin
            st   <= S_IDLE;
            tmr  <= '0;
            hold <= K_NONE;
            done <= 1'b0;
            irq  <= 1'b0;
            res  <= '0;
        end else begin
            st  <= nxt;
            irq <= fin;
            if (nxt != st)  tmr <= '0;
            else if (tick)  tmr <= tmr + 1'b1;
            if (fin) begin
                res  <= fin_res;
                hold <= fin_hold;
                done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/usbsc_drive.sv
// Maps the sequencer stage and held request onto D+/D- drive enables.
// Purely combinational from registered state, so enables follow the
// stage register without extra delay.
module usbsc_drive
    import usbsc_pkg::*;
(
    input  st_t           st,
    input  hold_t         hold,
    output logic [ND-1:0] drv
);
    // One drive pattern per stage
    always_comb begin
        drv = '0;
        case (st)
            S_DCD:  drv[D_IDP] = 1'b1;
            S_PRI:  begin drv[D_DPV] = 1'b1; drv[D_DMK] = 1'b1; end
            S_SEC:  begin drv[D_DMV] = 1'b1; drv[D_DPK] = 1'b1; end
            S_HV12: begin drv[D_DPK] = 1'b1; drv[D_DMH] = 1'b1; end
            S_HV9:  begin drv[D_DPH] = 1'b1; drv[D_DMK] = 1'b1; end
            S_DONE: begin
                if (hold == K_12) begin
                    drv[D_DPK] = 1'b1; drv[D_DMH] = 1'b1;
                end else if (hold == K_9) begin
                    drv[D_DPH] = 1'b1; drv[D_DMK] = 1'b1;
                end
            end
            default: drv = '0;
        endcase
    end
endmodule

// File: rtl/usb_src_classifier.sv
// Top level of the USB input source classifier: tick divider, flag
// filter, sequencer and drive decode. Assumes vbus_present is already
// synchronous to clk; all other flag inputs may be asynchronous.
module usb_src_classifier
    import usbsc_pkg::*;
#(
    parameter int TICK_DIV     = 125000,
    parameter int FILT_TICKS   = 2,
    parameter int DCD_TICKS    = 500,
    parameter int SETTLE_TICKS = 40,
    parameter int HV_TICKS     = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vbus_present,
    input  logic       hv12_en,
    input  logic       hv9_en,
    input  logic       dcd_ok,
    input  logic       pri_hi,
    input  logic       sec_hi,
    input  logic [2:0] dp_win,
    input  logic [2:0] dm_win,
    input  logic       hv_up,
    output logic       dp_idp_src_en,
    output logic       dp_vsrc_en,
    output logic       dm_vsrc_en,
    output logic       dp_isink_en,
    output logic       dm_isink_en,
    output logic       dp_hv_src_en,
    output logic       dm_hv_src_en,
    output logic       det_done,
    output logic       det_irq,
    output logic [6:0] ilim_code,
    output logic [2:0] src_stat
);
    logic             tick;
    logic [NFLAG-1:0] raw_flags;
    logic [NFLAG-1:0] flags;
    st_t              st;
    hold_t            hold;
    res_t             res;
    logic [ND-1:0]    drv;

    assign raw_flags = {dm_win, dp_win, hv_up, sec_hi, pri_hi, dcd_ok};

    usbsc_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    usbsc_flag_filter #(.W(NFLAG), .FILT(FILT_TICKS)) u_filt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(raw_flags), .clean(flags)
    );

    usbsc_seq #(
        .DCD_TICKS(DCD_TICKS), .SETTLE_TICKS(SETTLE_TICKS), .HV_TICKS(HV_TICKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .vbus(vbus_present),
        .hv12_en(hv12_en), .hv9_en(hv9_en), .flags(flags),
        .st(st), .hold(hold), .done(det_done), .irq(det_irq), .res(res)
    );

    usbsc_drive u_drive (
        .st(st), .hold(hold), .drv(drv)
    );

    assign dp_idp_src_en = drv[D_IDP];
    assign dp_vsrc_en    = drv[D_DPV];
    assign dm_vsrc_en    = drv[D_DMV];
    assign dp_isink_en   = drv[D_DPK];
    assign dm_isink_en   = drv[D_DMK];
    assign dp_hv_src_en  = drv[D_DPH];
    assign dm_hv_src_en  = drv[D_DMH];
    assign ilim_code     = res.ilim;
    assign src_stat      = res.stat;
endmodule

// File: rtl/usbsc_checker.sv
// Port-level properties of the classifier, bound to every instance of
// the top module. Observes only top-level ports.
module usbsc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       vbus_present,
    input logic       dp_idp_src_en,
    input logic       dp_vsrc_en,
    input logic       dm_vsrc_en,
    input logic       dp_isink_en,
    input logic       dm_isink_en,
    input logic       dp_hv_src_en,
    input logic       dm_hv_src_en,
    input logic       det_done,
    input logic       det_irq,
    input logic [6:0] ilim_code,
    input logic [2:0] src_stat
);
    logic [6:0] drv;
    assign drv = {dm_hv_src_en, dp_hv_src_en, dm_isink_en, dp_isink_en,
                  dm_vsrc_en, dp_vsrc_en, dp_idp_src_en};

    a_r12_removal_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !vbus_present |=> (!det_done && !det_irq && drv == 7'd0
                           && ilim_code == 7'd0 && src_stat == 3'd0));

    a_r11_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        det_irq |=> !det_irq);

    a_r11_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        det_irq |-> det_done);

    a_r11_done_rise_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_done) |-> det_irq);

    a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (det_done && $past(det_done)) |-> ($stable(ilim_code) && $stable(src_stat)));

    a_r9_stat_legal: assert property (@(posedge clk) disable iff (!rst_n)
        det_done |-> (src_stat != 3'd0 && src_stat != 3'd7));

    a_r6_dp_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
        dp_isink_en |-> !(dp_hv_src_en || dp_vsrc_en || dp_idp_src_en));

    a_r7_dm_no_fight: assert property (@(posedge clk) disable iff (!rst_n)
        dm_isink_en |-> !(dm_hv_src_en || dm_vsrc_en));

    a_r2_drive_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drv) <= 2);
endmodule

bind usb_src_classifier usbsc_checker u_chk (.*);

// File: tb/usb_src_classifier_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module usb_src_classifier_bench;
    localparam int TDIV = 4;
    localparam int DCDT = 20;

    logic clk = 1'b0;
    logic rst_n;
    logic vbus_present, hv12_en, hv9_en, dcd_ok, pri_hi, sec_hi, hv_up;
    logic [2:0] dp_win, dm_win;
    logic dp_idp_src_en, dp_vsrc_en, dm_vsrc_en, dp_isink_en, dm_isink_en;
    logic dp_hv_src_en, dm_hv_src_en, det_done, det_irq;
    logic [6:0] ilim_code;
    logic [2:0] src_stat;
    logic [6:0] drv;

    int n_chk = 0;
    int n_bad = 0;
    int cyc;
    int irq_cnt;
    bit seen9;

    always #4 clk = ~clk;

    assign drv = {dm_hv_src_en, dp_hv_src_en, dm_isink_en, dp_isink_en,
                  dm_vsrc_en, dp_vsrc_en, dp_idp_src_en};

    usb_src_classifier #(
        .TICK_DIV(TDIV), .FILT_TICKS(2), .DCD_TICKS(DCDT),
        .SETTLE_TICKS(4), .HV_TICKS(8)
    ) u_usb_src_classifier (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic set_in(input bit d, input bit p, input bit s, input logic [2:0] dp,
                          input logic [2:0] dm, input bit h12, input bit h9, input bit up);
        dcd_ok = d; pri_hi = p; sec_hi = s; dp_win = dp; dm_win = dm;
        hv12_en = h12; hv9_en = h9; hv_up = up;
        repeat (30) @(negedge clk);
    endtask

    // Plug in and wait for the interrupt; counts cycles and 9 V pattern
    task automatic plug_wait();
        vbus_present = 1'b1;
        cyc = 0; irq_cnt = 0; seen9 = 0;
        while (irq_cnt == 0 && cyc < 600) begin
            @(negedge clk);
            cyc++;
            if (dp_hv_src_en && dm_isink_en) seen9 = 1;
            if (det_irq) irq_cnt++;
        end
        chk("R11 irq seen", irq_cnt, 1);
    endtask

    task automatic unplug_check();
        @(negedge clk);
        chk("R11 irq single", int'(det_irq), 0);
        chk("R11 done held", int'(det_done), 1);
        vbus_present = 1'b0;
        @(negedge clk);
        chk("R12 done clear", int'(det_done), 0);
        chk("R12 drive off", int'(drv), 0);
        chk("R12 code clear", int'(ilim_code), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic expect_res(input string req, input int il, input int st);
        chk({req, " ilim"}, int'(ilim_code), il);
        chk({req, " stat"}, int'(src_stat), st);
        chk({req, " done"}, int'(det_done), 1);
    endtask

    task automatic t_contact_drive();
        set_in(0, 0, 0, 3'b000, 3'b000, 0, 0, 0);
        vbus_present = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 contact drive", int'(drv), 1);
        vbus_present = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_sdp();
        set_in(1, 0, 0, 3'b000, 3'b000, 1, 1, 1);
        plug_wait();
        expect_res("R3 sdp", 10, 1);
        chk("R2 fast path", int'(cyc < DCDT * TDIV), 1);
        unplug_check();
    endtask

    task automatic t_cdp();
        set_in(1, 1, 0, 3'b000, 3'b000, 1, 1, 1);
        plug_wait();
        expect_res("R4 cdp", 30, 2);
        unplug_check();
    endtask

    task automatic t_dcp_plain();
        set_in(1, 1, 1, 3'b000, 3'b000, 0, 0, 1);
        plug_wait();
        expect_res("R5 dcp", 65, 3);
        chk("R5 drive", int'(drv), 0);
        unplug_check();
    endtask

    task automatic t_hv12();
        set_in(1, 1, 1, 3'b000, 3'b000, 1, 1, 1);
        plug_wait();
        expect_res("R6 hv12", 30, 4);
        repeat (5) @(negedge clk);
        chk("R6 hold pair", int'(drv), 7'b1001000);
        chk("R6 no 9v", int'(seen9), 0);
        unplug_check();
    endtask

    task automatic t_hv9();
        set_in(1, 1, 1, 3'b000, 3'b000, 0, 1, 1);
        plug_wait();
        expect_res("R7 hv9", 30, 4);
        chk("R7 hold pair", int'(drv), 7'b0110000);
        unplug_check();
    endtask

    task automatic t_hv_fail();
        set_in(1, 1, 1, 3'b000, 3'b000, 1, 1, 0);
        plug_wait();
        expect_res("R7 fallback", 65, 3);
        chk("R7 9v tried", int'(seen9), 1);
        chk("R7 released", int'(drv), 0);
        unplug_check();
    endtask

    task automatic t_div(input logic [2:0] dp, input logic [2:0] dm, input int il, input int st);
        set_in(0, 0, 0, dp, dm, 1, 1, 1);
        plug_wait();
        expect_res("R9 divider", il, st);
        chk("R8 timeout wait", int'(cyc >= DCDT * TDIV), 1);
        unplug_check();
    endtask

    task automatic t_unknown();
        set_in(0, 0, 0, 3'b011, 3'b001, 0, 0, 0);
        plug_wait();
        expect_res("R10 unknown", 10, 5);
        unplug_check();
    endtask

    task automatic t_glitch();
        set_in(0, 0, 0, 3'b001, 3'b001, 0, 0, 0);
        vbus_present = 1'b1;
        repeat (10) @(negedge clk);
        dcd_ok = 1'b1;
        @(negedge clk);
        dcd_ok = 1'b0;
        cyc = 0; irq_cnt = 0;
        while (irq_cnt == 0 && cyc < 600) begin
            @(negedge clk);
            cyc++;
            if (det_irq) irq_cnt++;
        end
        expect_res("R13 glitch ignored", 40, 6);
        unplug_check();
    endtask

    // Sweep removal across the completion cycle of a charging-port run
    task automatic t_collide();
        set_in(1, 1, 0, 3'b000, 3'b000, 0, 0, 0);
        for (int k = 0; k < 40; k++) begin
            int nirq = 0;
            vbus_present = 1'b1;
            for (int c = 0; c < k; c++) begin
                @(negedge clk);
                if (det_irq) nirq++;
            end
            vbus_present = 1'b0;
            @(negedge clk);
            chk("R12 collide irq", int'(det_irq), 0);
            chk("R12 collide done", int'(det_done), 0);
            chk("R12 collide drive", int'(drv), 0);
            chk("R11 at most one", int'(nirq <= 1), 1);
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        rst_n = 1'b0;
        vbus_present = 1'b0;
        hv12_en = 0; hv9_en = 0; dcd_ok = 0; pri_hi = 0; sec_hi = 0; hv_up = 0;
        dp_win = '0; dm_win = '0;
        repeat (5) @(negedge clk);
        chk("R1 reset done", int'(det_done), 0);
        chk("R1 reset irq", int'(det_irq), 0);
        chk("R1 reset drive", int'(drv), 0);
        chk("R1 reset codes", int'({ilim_code, src_stat}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle outputs", int'({det_done, det_irq, drv, ilim_code, src_stat}), 0);
        t_contact_drive();
        t_sdp();
        t_cdp();
        t_dcp_plain();
        t_hv12();
        t_hv9();
        t_hv_fail();
        t_div(3'b100, 3'b010, 42, 6);
        t_div(3'b001, 3'b001, 40, 6);
        t_div(3'b010, 3'b100, 20, 6);
        t_div(3'b100, 3'b100, 48, 6);
        t_unknown();
        t_glitch();
        t_collide();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R11 act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule